// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block gathers the expiry pulses of a bank of countdown timers into one register word and drives one interrupt line per timer. The low field of the word holds a read/write enable per channel. The next field holds a sticky status flag per channel. Hardware sets a flag when its channel expires. Software clears a flag by writing a one to it.

A channel's interrupt line goes high only when the channel expires while its enable bit is already set. The line stays high until software clears that channel's status flag. Software reads the whole word through `rd_data` and updates it with a single-cycle write strobe. Each expiry input is a one-cycle pulse per expiry event.

Top module: `timer_irq_stat`

## Requirements
- R1: After reset, `rd_data` reads zero and every `irq_o` line is low.
- R2: A write loads `wr_data[NCH-1:0]` into the enable field (`rd_data[NCH-1:0]`, bit i for channel i) on the next cycle. Enables hold their value between writes.
- R3: An expiry pulse on channel i sets status bit `rd_data[NCH+i]` on the next cycle, whether or not the enable for channel i is set.
- R4: An expiry on channel i while enable bit i is set drives `irq_o[i]` high on the next cycle. The line stays high until its status flag is cleared.
- R5: An expiry on channel i while enable bit i is clear leaves `irq_o[i]` low. Setting enable bit i afterwards, with the status flag already set, does not raise `irq_o[i]`.
- R6: A write with `wr_data[NCH+i]` = 1 clears status flag i and lowers `irq_o[i]` on the next cycle. A write with that bit at 0 leaves the flag and the line unchanged.
- R7: When an expiry on channel i and a clearing write to status bit i fall in the same cycle, the flag ends up set. If enable i was set in that cycle, `irq_o[i]` is high afterwards.
- R8: Bits 31 down to 2*NCH of `rd_data` always read zero, whatever was written to them.
- R9: Channels are independent: an expiry, clear or enable write on one channel does not alter the flags or lines of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| expire_i | input | NCH | One-cycle expiry pulse per channel |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: enables in the low field, clear mask in the next field |
| rd_data | output | 32 | Register readback |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
Two functions can fall in the same cycle: the hardware set of a status flag by an expiry, and the software clear of that flag by a write. Directed steps pulse `expire_i[i]` in the exact cycle that `wr_data[NCH+i]` is written as one, once with the enable set and once with it clear. The flag must survive, and the line must follow the enable that held in that cycle. A long pseudo-random phase also mixes expiries, enable writes and clears on all channels. Every clock, that phase is judged against a behavioural model of the register.

// File: rtl/timer_irq_stat.sv
module timer_irq_stat #(
  parameter int NCH    = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    expire_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq_o
);
  localparam int USED = 2 * NCH;

  logic [NCH-1:0] en_q, st_q, irq_q;
  logic [NCH-1:0] clr;

  assign clr = wr_en ? wr_data[USED-1:NCH] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= '0;
    end else begin
      if (wr_en) en_q <= wr_data[NCH-1:0];
      st_q  <= (st_q & ~clr) | expire_i;
      irq_q <= (irq_q & ~clr) | (expire_i & en_q);
    end
  end

  assign rd_data = {{(DATA_W-USED){1'b0}}, st_q, en_q};
  assign irq_o   = irq_q;
endmodule

// File: rtl/timer_irq_stat_chk.sv
module timer_irq_stat_chk #(
  parameter int NCH    = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    expire_i,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NCH-1:0]    irq_o
);
  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[NCH-1:0] == $past(wr_data[NCH-1:0]));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3
    expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i[i] |=> rd_data[NCH+i]);
    // R4
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> rd_data[NCH+i]);
    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[i]) |-> $past(expire_i[i] && rd_data[i]));
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[NCH+i] && !expire_i[i]) |=> (!rd_data[NCH+i] && !irq_o[i]));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[NCH+i] && expire_i[i] && rd_data[i]) |=> (rd_data[NCH+i] && irq_o[i]));
  end
endmodule

bind timer_irq_stat timer_irq_stat_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .expire_i(expire_i), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/timer_irq_stat_tb.sv
`timescale 1ns/1ps
module timer_irq_stat_tb;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  expire_i = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  irq_o;

  timer_irq_stat #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  string tag = "R1";

  bit m_en[NCH];
  bit m_st[NCH];
  bit m_irq[NCH];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_en[i] = 0; m_st[i] = 0; m_irq[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit clr_b, old_en;
        clr_b  = wr_en && wr_data[NCH+i];
        old_en = m_en[i];
        if (clr_b) begin m_st[i] = 0; m_irq[i] = 0; end
        if (expire_i[i]) begin
          m_st[i] = 1;
          if (old_en) m_irq[i] = 1;
        end
        if (wr_en) m_en[i] = wr_data[i];
      end
    end
    started <= 1;
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int i = 0; i < NCH; i++) begin
      w[i] = m_en[i];
      w[NCH+i] = m_st[i];
    end
    return w;
  endfunction

  function automatic logic [4:0] model_irq();
    logic [4:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i] = m_irq[i];
    return v;
  endfunction

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rd_data !== model_word() || irq_o !== model_irq()) begin
        errors++;
        $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                 tag, rd_data, irq_o, model_word(), model_irq());
      end
    end
  end

  task automatic step(input logic [4:0] e, input logic w, input logic [31:0] d);
    @(negedge clk);
    #0.5;
    expire_i = e; wr_en = w; wr_data = d;
    @(negedge clk);
    #0.5;
    expire_i = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic expect_pins(input string t, input logic [31:0] word, input logic [4:0] irq);
    @(negedge clk);
    #1;
    checks++;
    if (rd_data !== word || irq_o !== irq) begin
      errors++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b", t, rd_data, irq_o, word, irq);
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 50000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    tag = "R1";
    expect_pins("R1", 32'h0, 5'h0);
    rst_n = 1'b1;
    expect_pins("R1", 32'h0, 5'h0);

    tag = "R2";
    step(5'h0, 1'b1, 32'h0000_0015);
    expect_pins("R2", 32'h0000_0015, 5'h0);

    tag = "R3";
    step(5'b00010, 1'b0, '0);
    expect_pins("R3", 32'h0000_0055, 5'h0);

    tag = "R4";
    step(5'b00001, 1'b0, '0);
    expect_pins("R4", 32'h0000_0075, 5'b00001);

    tag = "R5";
    step(5'h0, 1'b1, 32'h0000_0017);
    expect_pins("R5", 32'h0000_0077, 5'b00001);

    tag = "R6";
    step(5'h0, 1'b1, 32'h0000_0037);
    expect_pins("R6", 32'h0000_0057, 5'b00000);
    step(5'h0, 1'b1, 32'h0000_0017);
    expect_pins("R6", 32'h0000_0057, 5'b00000);

    tag = "R7";
    step(5'b00100, 1'b1, 32'h0000_0097);
    expect_pins("R7", 32'h0000_00D7, 5'b00100);
    step(5'b01000, 1'b1, 32'h0000_0107);
    expect_pins("R7", 32'h0000_01C7, 5'b00100);

    tag = "R8";
    step(5'h0, 1'b1, 32'hFFFF_FC07);
    expect_pins("R8", 32'h0000_01C7, 5'b00100);

    tag = "R9";
    step(5'b10000, 1'b1, 32'h0000_0010);
    expect_pins("R9", 32'h0000_03D0, 5'b00100);
    step(5'b10000, 1'b0, '0);
    expect_pins("R9", 32'h0000_03D0, 5'b10100);

    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      #0.5;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      expire_i = lfsr[4:0] & lfsr[12:8];
      wr_en    = lfsr[17] & lfsr[19];
      wr_data  = {lfsr[7:0], lfsr[31:8]};
    end
    @(negedge clk);
    #0.5;
    expire_i = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule